// File: doc/BRIEF.md
# Dual Byte Queue with Fill-Level Triggers

This block holds two byte queues for a serial bus controller: an outbound queue that software fills and the bus serializer drains, and an inbound queue that the serializer fills and software drains. Each queue keeps a live occupancy count and full and empty flags. It has a flush strobe and a programmable fill-level trigger, and the trigger output can drive an interrupt or a DMA engine.

A DMA request path sits beside each queue. The DMA mode can stay armed until software changes it, or it can be armed for a single frame, in which case it disarms itself when the bus reports a START or a STOP. The DMA transfer width can be one byte or a half-word. In half-word width a request is raised only when two byte slots (outbound) or two bytes (inbound) are ready. The block sees only push and pop strobes and START/STOP pulses. It does no bus signalling and makes no interrupt decisions.

Top module: `dual_byte_queue`

## Requirements
- R1: The outbound trigger `tx_trig_hit` is high when `tx_count` is at or below a threshold picked by the 2-bit setting: 0 gives 0, 1 gives DEPTH/4, 2 gives DEPTH/2, 3 gives DEPTH-1. The setting is 3 after reset.
- R2: The inbound trigger `rx_trig_hit` is high when `rx_count` is at or above a threshold picked by the 2-bit setting: 0 gives 1, 1 gives DEPTH/4, 2 gives DEPTH/2, 3 gives (3*DEPTH)/4. The setting is 0 after reset.
- R3: A flush strobe empties its queue in one cycle: the count is 0 and the overrun and underrun flags are clear on the next cycle. A push or pop in the same cycle as a flush has no effect.
- R4: Each queue returns bytes in the order they were pushed. Its count tracks occupancy. `tx_full` is high exactly when `tx_count` equals DEPTH, and `rx_empty` is high exactly when `rx_count` is 0.
- R5: A push into a full queue is dropped and leaves the count unchanged. It sets that queue's sticky overrun flag.
- R6: While a queue is empty its pop data reads 0. A pop of an empty queue sets that queue's sticky underrun flag.
- R7: The DMA mode encoding is 0 off, 1 one frame, 2 continuous, 3 treated as off. A DMA request is raised only in modes 1 and 2, and only while that queue's trigger is high.
- R8: Mode 1 returns to 0 on the cycle after a `bus_start` or `bus_stop` pulse unless `cfg_wr` is high in the same cycle. Mode 2 is not affected by those pulses.
- R9: With `cfg_dma_half` set, the outbound request needs at least 2 free slots and the inbound request needs at least 2 stored bytes. With it clear, 1 of each is enough.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Loads all cfg_* fields |
| cfg_tx_trig | input | 2 | Outbound trigger setting |
| cfg_rx_trig | input | 2 | Inbound trigger setting |
| cfg_tx_dma | input | 2 | Outbound DMA mode |
| cfg_rx_dma | input | 2 | Inbound DMA mode |
| cfg_dma_half | input | 1 | Half-word DMA width |
| bus_start | input | 1 | START seen on the bus (pulse) |
| bus_stop | input | 1 | STOP seen on the bus (pulse) |
| tx_push | input | 1 | Software writes a byte to the outbound queue |
| tx_push_data | input | 8 | Outbound byte |
| tx_pop | input | 1 | Serializer takes the head outbound byte |
| tx_pop_data | output | 8 | Head outbound byte, 0 when empty |
| tx_flush | input | 1 | Empties the outbound queue |
| rx_push | input | 1 | Serializer delivers an inbound byte |
| rx_push_data | input | 8 | Inbound byte |
| rx_pop | input | 1 | Software takes the head inbound byte |
| rx_pop_data | output | 8 | Head inbound byte, 0 when empty |
| rx_flush | input | 1 | Empties the inbound queue |
| tx_count | output | 5 | Outbound occupancy |
| rx_count | output | 5 | Inbound occupancy |
| tx_full | output | 1 | Outbound queue full |
| rx_empty | output | 1 | Inbound queue empty |
| tx_trig_hit | output | 1 | Outbound trigger |
| rx_trig_hit | output | 1 | Inbound trigger |
| tx_overrun | output | 1 | Sticky outbound overrun |
| tx_underrun | output | 1 | Sticky outbound underrun |
| rx_overrun | output | 1 | Sticky inbound overrun |
| rx_underrun | output | 1 | Sticky inbound underrun |
| tx_dma_req | output | 1 | Outbound DMA request |
| rx_dma_req | output | 1 | Inbound DMA request |
| tx_dma_mode | output | 2 | Current outbound DMA mode |
| rx_dma_mode | output | 2 | Current inbound DMA mode |

## Verification
The in-line assertions check on every cycle that occupancy never passes the depth, that a flush zeroes the count, and that idle cycles leave the count alone. They also check that overflow and underflow set the sticky flags, and that a one-frame DMA arming drops at START or STOP while continuous arming holds. Only the bench scenarios can show byte ordering through the queues, the exact threshold of each trigger setting at its edge, and the half-word free-space and availability limits on the requests.

// File: rtl/bq_pkg.sv
package bq_pkg;
   typedef enum logic [1:0] {
      DMA_OFF   = 2'd0,
      DMA_FRAME = 2'd1,
      DMA_HOLD  = 2'd2,
      DMA_RSVD  = 2'd3
   } dma_mode_e;

   localparam logic [1:0] TX_TRIG_RESET = 2'd3;
   localparam logic [1:0] RX_TRIG_RESET = 2'd0;
endpackage

// File: rtl/bq_fifo_core.sv
module bq_fifo_core #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] pop_data,
   input  logic          flush,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty,
   output logic          overrun,
   output logic          underrun
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_depth_chk
      $error("bq_fifo_core: DEPTH must be a power of two and at least 4");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count_q;
   logic          ovf_q, udf_q;
   logic          push_ok, pop_ok;

   assign full    = (count_q == CW'(DEPTH));
   assign empty   = (count_q == '0);
   assign push_ok = push && !full && !flush;
   assign pop_ok  = pop && !empty && !flush;

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count_q <= '0;
         ovf_q   <= 1'b0;
         udf_q   <= 1'b0;
      end else if (flush) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count_q <= '0;
         ovf_q   <= 1'b0;
         udf_q   <= 1'b0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         if (push_ok && !pop_ok)      count_q <= count_q + 1'b1;
         else if (!push_ok && pop_ok) count_q <= count_q - 1'b1;
         if (push && full) ovf_q <= 1'b1;
         if (pop && empty) udf_q <= 1'b1;
      end
   end

   assign pop_data = empty ? '0 : mem[rd_ptr];
   assign count    = count_q;
   assign overrun  = ovf_q;
   assign underrun = udf_q;

   // R4
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CW'(DEPTH));
   // R3
   flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count_q == '0 && !ovf_q && !udf_q));
   // R4
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!push && !pop && !flush) |=> $stable(count_q));
   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> (ovf_q && $stable(count_q)));
   // R6
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !flush) |=> udf_q);
endmodule

// File: rtl/bq_trigger.sv
module bq_trigger #(
   parameter int DEPTH      = 16,
   parameter bit TOWARD_BUS = 1'b1,
   localparam int CW        = $clog2(DEPTH + 1)
) (
   input  logic [CW-1:0] count,
   input  logic [1:0]    level,
   output logic          hit
);
   localparam logic [CW-1:0] LVL_QTR  = CW'(DEPTH / 4);
   localparam logic [CW-1:0] LVL_HALF = CW'(DEPTH / 2);
   localparam logic [CW-1:0] LVL_3Q   = CW'((3 * DEPTH) / 4);
   localparam logic [CW-1:0] LVL_TOP  = CW'(DEPTH - 1);

   if (TOWARD_BUS) begin : g_drain
      always_comb begin
         unique case (level)
            2'd0:    hit = (count == '0);
            2'd1:    hit = (count <= LVL_QTR);
            2'd2:    hit = (count <= LVL_HALF);
            default: hit = (count <= LVL_TOP);
         endcase
      end
   end else begin : g_fill
      always_comb begin
         unique case (level)
            2'd0:    hit = (count != '0);
            2'd1:    hit = (count >= LVL_QTR);
            2'd2:    hit = (count >= LVL_HALF);
            default: hit = (count >= LVL_3Q);
         endcase
      end
   end
endmodule

// File: rtl/bq_dma_ctl.sv
module bq_dma_ctl
   import bq_pkg::*;
#(
   parameter int DEPTH      = 16,
   parameter bit TOWARD_BUS = 1'b1,
   localparam int CW        = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic [1:0]    cfg_mode,
   input  logic          bus_start,
   input  logic          bus_stop,
   input  logic          half,
   input  logic          trig_hit,
   input  logic [CW-1:0] count,
   output logic [1:0]    mode,
   output logic          req
);
   dma_mode_e     mode_q;
   logic          armed, room_ok;
   logic [CW-1:0] need;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                         mode_q <= DMA_OFF;
      else if (cfg_wr)                                    mode_q <= dma_mode_e'(cfg_mode);
      else if ((bus_start || bus_stop) && mode_q == DMA_FRAME) mode_q <= DMA_OFF;
   end

   assign need  = half ? CW'(2) : CW'(1);
   assign armed = (mode_q == DMA_FRAME) || (mode_q == DMA_HOLD);

   if (TOWARD_BUS) begin : g_space
      assign room_ok = (CW'(DEPTH) - count) >= need;
   end else begin : g_avail
      assign room_ok = count >= need;
   end

   assign req  = armed && trig_hit && room_ok;
   assign mode = mode_q;

   // R8
   frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_wr && (bus_start || bus_stop) && mode_q == DMA_FRAME) |=> mode_q == DMA_OFF);
   // R8
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_wr && mode_q == DMA_HOLD) |=> mode_q == DMA_HOLD);
endmodule

// File: rtl/dual_byte_queue.sv
module dual_byte_queue
   import bq_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic [1:0]    cfg_tx_trig,
   input  logic [1:0]    cfg_rx_trig,
   input  logic [1:0]    cfg_tx_dma,
   input  logic [1:0]    cfg_rx_dma,
   input  logic          cfg_dma_half,
   input  logic          bus_start,
   input  logic          bus_stop,
   input  logic          tx_push,
   input  logic [7:0]    tx_push_data,
   input  logic          tx_pop,
   output logic [7:0]    tx_pop_data,
   input  logic          tx_flush,
   input  logic          rx_push,
   input  logic [7:0]    rx_push_data,
   input  logic          rx_pop,
   output logic [7:0]    rx_pop_data,
   input  logic          rx_flush,
   output logic [CW-1:0] tx_count,
   output logic [CW-1:0] rx_count,
   output logic          tx_full,
   output logic          rx_empty,
   output logic          tx_trig_hit,
   output logic          rx_trig_hit,
   output logic          tx_overrun,
   output logic          tx_underrun,
   output logic          rx_overrun,
   output logic          rx_underrun,
   output logic          tx_dma_req,
   output logic          rx_dma_req,
   output logic [1:0]    tx_dma_mode,
   output logic [1:0]    rx_dma_mode
);
   logic [1:0] tx_lvl_q, rx_lvl_q;
   logic       half_q;
   logic       tx_empty_nc, rx_full_nc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_lvl_q <= TX_TRIG_RESET;
         rx_lvl_q <= RX_TRIG_RESET;
         half_q   <= 1'b0;
      end else if (cfg_wr) begin
         tx_lvl_q <= cfg_tx_trig;
         rx_lvl_q <= cfg_rx_trig;
         half_q   <= cfg_dma_half;
      end
   end

   bq_fifo_core #(.DEPTH(DEPTH), .DW(8)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .push_data(tx_push_data),
      .pop(tx_pop), .pop_data(tx_pop_data), .flush(tx_flush), .count(tx_count),
      .full(tx_full), .empty(tx_empty_nc), .overrun(tx_overrun), .underrun(tx_underrun));

   bq_fifo_core #(.DEPTH(DEPTH), .DW(8)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rx_push_data),
      .pop(rx_pop), .pop_data(rx_pop_data), .flush(rx_flush), .count(rx_count),
      .full(rx_full_nc), .empty(rx_empty), .overrun(rx_overrun), .underrun(rx_underrun));

   bq_trigger #(.DEPTH(DEPTH), .TOWARD_BUS(1'b1)) u_txtrig (
      .count(tx_count), .level(tx_lvl_q), .hit(tx_trig_hit));

   bq_trigger #(.DEPTH(DEPTH), .TOWARD_BUS(1'b0)) u_rxtrig (
      .count(rx_count), .level(rx_lvl_q), .hit(rx_trig_hit));

   bq_dma_ctl #(.DEPTH(DEPTH), .TOWARD_BUS(1'b1)) u_txdma (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_tx_dma),
      .bus_start(bus_start), .bus_stop(bus_stop), .half(half_q),
      .trig_hit(tx_trig_hit), .count(tx_count), .mode(tx_dma_mode), .req(tx_dma_req));

   bq_dma_ctl #(.DEPTH(DEPTH), .TOWARD_BUS(1'b0)) u_rxdma (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_rx_dma),
      .bus_start(bus_start), .bus_stop(bus_stop), .half(half_q),
      .trig_hit(rx_trig_hit), .count(rx_count), .mode(rx_dma_mode), .req(rx_dma_req));

   // R7
   tx_req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_dma_req |-> (tx_trig_hit && (tx_dma_mode == 2'd1 || tx_dma_mode == 2'd2)));
   // R7
   rx_req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_dma_req |-> (rx_trig_hit && (rx_dma_mode == 2'd1 || rx_dma_mode == 2'd2)));
endmodule

// File: tb/sim_dual_byte_queue.sv
module sim_dual_byte_queue;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 0, cfg_dma_half = 0, bus_start = 0, bus_stop = 0;
   logic [1:0] cfg_tx_trig = 0, cfg_rx_trig = 0, cfg_tx_dma = 0, cfg_rx_dma = 0;
   logic tx_push = 0, tx_pop = 0, tx_flush = 0, rx_push = 0, rx_pop = 0, rx_flush = 0;
   logic [7:0] tx_push_data = 0, rx_push_data = 0, tx_pop_data, rx_pop_data;
   logic [4:0] tx_count, rx_count;
   logic tx_full, rx_empty, tx_trig_hit, rx_trig_hit;
   logic tx_overrun, tx_underrun, rx_overrun, rx_underrun, tx_dma_req, rx_dma_req;
   logic [1:0] tx_dma_mode, rx_dma_mode;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [7:0] sb_tx [$];
   logic [7:0] sb_rx [$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   dual_byte_queue #(.DEPTH(DEPTH)) u0 (.*);

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cfg(logic [1:0] tt, logic [1:0] rt, logic [1:0] tm, logic [1:0] rm, logic h);
      cfg_wr = 1; cfg_tx_trig = tt; cfg_rx_trig = rt; cfg_tx_dma = tm; cfg_rx_dma = rm; cfg_dma_half = h;
      @(negedge clk);
      cfg_wr = 0;
   endtask

   // driver: pushes and records expected bytes
   task automatic push_tx(logic [7:0] d);
      if (tx_count < DEPTH) sb_tx.push_back(d);
      tx_push = 1; tx_push_data = d;
      @(negedge clk);
      tx_push = 0;
   endtask

   task automatic push_rx(logic [7:0] d);
      if (rx_count < DEPTH) sb_rx.push_back(d);
      rx_push = 1; rx_push_data = d;
      @(negedge clk);
      rx_push = 0;
   endtask

   // monitor: compares head byte with scoreboard, then pops
   task automatic pop_tx(string req);
      logic [7:0] exp;
      exp = (sb_tx.size() > 0) ? sb_tx.pop_front() : 8'd0;
      chk(req, tx_pop_data, exp);
      tx_pop = 1;
      @(negedge clk);
      tx_pop = 0;
   endtask

   task automatic pop_rx(string req);
      logic [7:0] exp;
      exp = (sb_rx.size() > 0) ? sb_rx.pop_front() : 8'd0;
      chk(req, rx_pop_data, exp);
      rx_pop = 1;
      @(negedge clk);
      rx_pop = 0;
   endtask

   task automatic flush_tx();
      tx_flush = 1;
      @(negedge clk);
      tx_flush = 0;
      sb_tx.delete();
   endtask

   task automatic flush_rx();
      rx_flush = 1;
      @(negedge clk);
      rx_flush = 0;
      sb_rx.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state
      chk("R4 reset tx_count", tx_count, 0);
      chk("R4 reset rx_empty", rx_empty, 1);
      chk("R4 reset tx_full", tx_full, 0);
      chk("R2 reset rx_trig", rx_trig_hit, 0);
      chk("R7 reset tx_dma_req", tx_dma_req, 0);

      // R1 default setting 3: hit up to DEPTH-1
      for (int i = 0; i < 15; i++) push_tx(8'(8'h30 + i));
      chk("R1 default at 15", tx_trig_hit, 1);
      push_tx(8'h3F);
      chk("R1 default at 16", tx_trig_hit, 0);
      chk("R4 full at 16", tx_full, 1);
      push_tx(8'hEE);
      chk("R5 count after drop", tx_count, 16);
      chk("R5 overrun", tx_overrun, 1);
      for (int i = 0; i < 16; i++) pop_tx("R4 tx order");
      chk("R6 empty pop data", tx_pop_data, 0);
      pop_tx("R6 empty pop data");
      chk("R6 underrun", tx_underrun, 1);
      chk("R6 count stays 0", tx_count, 0);
      flush_tx();
      chk("R3 flush clears underrun", tx_underrun, 0);
      chk("R3 flush clears overrun", tx_overrun, 0);

      // R1 other settings
      cfg(2'd1, 2'd0, 2'd0, 2'd0, 1'b0);
      for (int i = 0; i < 4; i++) push_tx(8'(i + 1));
      chk("R1 quarter at 4", tx_trig_hit, 1);
      push_tx(8'h05);
      chk("R1 quarter at 5", tx_trig_hit, 0);
      cfg(2'd2, 2'd0, 2'd0, 2'd0, 1'b0);
      chk("R1 half at 5", tx_trig_hit, 1);
      for (int i = 0; i < 3; i++) push_tx(8'(i + 6));
      chk("R1 half at 8", tx_trig_hit, 1);
      push_tx(8'h09);
      chk("R1 half at 9", tx_trig_hit, 0);
      cfg(2'd0, 2'd0, 2'd0, 2'd0, 1'b0);
      chk("R1 empty-only at 9", tx_trig_hit, 0);
      pop_tx("R4 tx order after cfg");
      // flush and push in same cycle
      tx_flush = 1; tx_push = 1; tx_push_data = 8'hAA;
      @(negedge clk);
      tx_flush = 0; tx_push = 0; sb_tx.delete();
      chk("R3 flush beats push", tx_count, 0);
      chk("R1 empty-only at 0", tx_trig_hit, 1);

      // R2 inbound triggers
      chk("R2 not-empty at 0", rx_trig_hit, 0);
      push_rx(8'hA0);
      chk("R2 not-empty at 1", rx_trig_hit, 1);
      chk("R4 rx_empty low", rx_empty, 0);
      cfg(2'd0, 2'd1, 2'd0, 2'd0, 1'b0);
      chk("R2 quarter at 1", rx_trig_hit, 0);
      for (int i = 0; i < 3; i++) push_rx(8'(8'hA1 + i));
      chk("R2 quarter at 4", rx_trig_hit, 1);
      cfg(2'd0, 2'd3, 2'd0, 2'd0, 1'b0);
      for (int i = 0; i < 7; i++) push_rx(8'(8'hB0 + i));
      chk("R2 three-quarter at 11", rx_trig_hit, 0);
      push_rx(8'hC0);
      chk("R2 three-quarter at 12", rx_trig_hit, 1);
      for (int i = 0; i < 12; i++) pop_rx("R4 rx order");
      chk("R4 rx_empty after drain", rx_empty, 1);
      // flush with pop in same cycle on inbound side
      push_rx(8'h11);
      rx_flush = 1; rx_pop = 1;
      @(negedge clk);
      rx_flush = 0; rx_pop = 0; sb_rx.delete();
      chk("R3 flush with pop", rx_count, 0);
      chk("R3 no underrun on flush", rx_underrun, 0);

      // R9 inbound half-word, continuous mode
      cfg(2'd3, 2'd0, 2'd0, 2'd2, 1'b1);
      push_rx(8'h51);
      chk("R9 rx half with 1", rx_dma_req, 0);
      push_rx(8'h52);
      chk("R9 rx half with 2", rx_dma_req, 1);
      bus_stop = 1;
      @(negedge clk);
      bus_stop = 0;
      chk("R8 hold survives stop", rx_dma_mode, 2);
      chk("R8 hold req stays", rx_dma_req, 1);
      pop_rx("R4 rx dma order");
      pop_rx("R4 rx dma order");

      // R7/R8 outbound one-frame
      cfg(2'd3, 2'd0, 2'd1, 2'd0, 1'b0);
      chk("R7 frame req", tx_dma_req, 1);
      bus_start = 1;
      @(negedge clk);
      bus_start = 0;
      chk("R8 frame cleared by start", tx_dma_mode, 0);
      chk("R7 req off after clear", tx_dma_req, 0);
      cfg(2'd3, 2'd0, 2'd1, 2'd0, 1'b0);
      bus_stop = 1;
      @(negedge clk);
      bus_stop = 0;
      chk("R8 frame cleared by stop", tx_dma_mode, 0);
      cfg(2'd3, 2'd0, 2'd3, 2'd0, 1'b0);
      chk("R7 mode 3 no req", tx_dma_req, 0);

      // R9 outbound half-word
      cfg(2'd3, 2'd0, 2'd2, 2'd0, 1'b1);
      for (int i = 0; i < 14; i++) push_tx(8'(8'h70 + i));
      chk("R9 tx half free 2", tx_dma_req, 1);
      push_tx(8'h7E);
      chk("R9 tx half free 1", tx_dma_req, 0);
      cfg(2'd3, 2'd0, 2'd2, 2'd0, 1'b0);
      chk("R9 tx byte free 1", tx_dma_req, 1);
      for (int i = 0; i < 15; i++) pop_tx("R4 tx dma order");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule